// File: doc/BRIEF.md
# Error interrupt and capture unit

This unit collects one-cycle error pulses from a queue engine. Each pulse sets a bit in a 32-bit sticky status word. The unit raises a single interrupt line whenever a status bit and its enable bit are both set, unless software has suppressed the line through a one-bit inhibit control. Software clears status bits by writing ones to them. It can also drop enable bits, for example to silence an error that keeps recurring.

Alongside the status word, the unit takes a snapshot of the first error it sees. It records which error won, the portal that caused it, the queue identifier involved, and, for memory ECC faults, the memory identifier, the failing address and the failing data words. Which context fields are kept depends on the class of the winning error. After a snapshot the capture registers stay frozen, and later errors only set status bits. Software reads the snapshot and then writes the captured error bit back, which arms the capture for the next error. A separate mask lets software keep chosen errors out of the capture while they still set status.

Top module: `err_capture_unit`

## Requirements
- R1: An event pulse sets the status bit at the same position one cycle later. Only bits 29..23, 17, 16, 11..8 and 4..0 are defined. Pulses on any other position have no effect on status or capture.
- R2: The status word sits at word address 0 and clears by writing one to a bit. If an event sets a bit in the same cycle that a write clears it, the bit ends up set.
- R3: `irq` is high when (status AND enable) is nonzero and inhibit bit 0 is clear. Enable is at word 1 and inhibit at word 3. A write to either register affects `irq` in the cycle after the write.
- R4: When the capture is armed, a cycle with eligible events loads the capture status word (word 4) with a one-hot value marking the highest-numbered eligible bit. The capture is armed when the capture status word is zero.
- R5: The portal capture (word 6) holds the portal type in bit 31 (0 software, 1 direct-connect) and the portal number in bits 9..0. These are recorded only when the winning bit is 17, 16, 11, 10, 9, 8, 3, 2 or 0; otherwise the word is loaded with zero.
- R6: The queue capture (word 5) holds the queue identifier in bits 23..0. It is recorded only when the winning bit is 17, 10, 8, 4, 3, 2, 1 or 0; otherwise it is loaded with zero.
- R7: When the winning bit is 25 or 24 (ECC), the memory identifier is stored in bits 28..24 of word 7 and the address in bits 15..0, and the data words are stored at words 8 onward. For any other winning bit these are loaded with zero.
- R8: While the capture status word is nonzero, new events still set status, but no capture register changes.
- R9: Writing ones to the capture status word clears those bits. Once it is zero the next eligible event is captured. Writing back the captured value re-arms the capture.
- R10: The disable word (word 2) is a read/write mask. Events whose mask bit is set are not captured, but they still set status.
- R11: After reset, every register reads zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| evt | input | 32 | Error event pulses, one bit per error |
| evt_dcp | input | 1 | Portal type of the current event |
| evt_port | input | PORT_W | Portal number of the current event |
| evt_qid | input | QID_W | Queue identifier of the current event |
| evt_memid | input | MEMID_W | ECC memory identifier |
| evt_eaddr | input | EADDR_W | ECC failing address |
| evt_edata | input | DATA_WORDS*32 | ECC failing data words |
| irq | output | 1 | Error interrupt |

## Verification
The hardest situations to reach are the collisions between the capture state and software writes. One is an event arriving while the capture is frozen. Another is a re-arm write landing in the same cycle as a new event. A third is a clear of status coinciding with a set of the same bit. The random stimulus therefore mixes sparse event bursts with frequent register writes, and sometimes writes back exactly the currently captured value. This makes freeze, re-arm and collision cycles occur many times. Directed cases reach multi-event cycles that span ECC, portal and queue classes, as well as masked events.

// File: rtl/err_capture_unit.sv
`timescale 1ns/1ps
module err_capture_unit #(
  parameter int DATA_WORDS = 16,
  parameter int QID_W      = 24,
  parameter int PORT_W     = 10,
  parameter int MEMID_W    = 5,
  parameter int EADDR_W    = 16,
  parameter int ADDR_W     = $clog2(8 + DATA_WORDS)
)(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_wr,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [31:0]              reg_wdata,
  output logic [31:0]              reg_rdata,
  input  logic [31:0]              evt,
  input  logic                     evt_dcp,
  input  logic [PORT_W-1:0]        evt_port,
  input  logic [QID_W-1:0]         evt_qid,
  input  logic [MEMID_W-1:0]       evt_memid,
  input  logic [EADDR_W-1:0]       evt_eaddr,
  input  logic [DATA_WORDS*32-1:0] evt_edata,
  output logic                     irq
);
  localparam logic [31:0] VALID_M = 32'h3F83_0F1F;
  localparam logic [31:0] PORT_M  = 32'h0003_0F0D;
  localparam logic [31:0] QID_M   = 32'h0002_051F;
  localparam logic [31:0] ECC_M   = 32'h0300_0000;
  localparam int IDX_W = $clog2(DATA_WORDS);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_DIS  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_INH  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_CAP  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_QID  = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_PORT = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_ECC  = ADDR_W'(7);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(8);

  logic [31:0] status_q, en_q, dis_q, cap_q;
  logic        inh_q;
  logic [QID_W-1:0]   cap_qid_q;
  logic               cap_dcp_q;
  logic [PORT_W-1:0]  cap_port_q;
  logic [MEMID_W-1:0] cap_memid_q;
  logic [EADDR_W-1:0] cap_eaddr_q;
  logic [DATA_WORDS*32-1:0] data_q;

  function automatic logic [4:0] top_bit(input logic [31:0] v);
    logic [4:0] r;
    r = '0;
    for (int i = 0; i < 32; i++)
      if (v[i]) r = 5'(i);
    return r;
  endfunction

  logic [31:0] evm, elig, hot;
  logic        take, p_cls, q_cls, e_cls;
  logic        we_stat, we_en, we_dis, we_inh, we_cap;

  assign evm     = evt & VALID_M;
  assign elig    = evm & ~dis_q;
  assign take    = (cap_q == '0) && (elig != '0);
  assign hot     = 32'd1 << top_bit(elig);
  assign p_cls   = |(hot & PORT_M);
  assign q_cls   = |(hot & QID_M);
  assign e_cls   = |(hot & ECC_M);
  assign we_stat = reg_wr && reg_addr == A_STAT;
  assign we_en   = reg_wr && reg_addr == A_EN;
  assign we_dis  = reg_wr && reg_addr == A_DIS;
  assign we_inh  = reg_wr && reg_addr == A_INH;
  assign we_cap  = reg_wr && reg_addr == A_CAP;
  assign irq     = (|(status_q & en_q)) && !inh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q    <= '0;
      en_q        <= '0;
      dis_q       <= '0;
      inh_q       <= 1'b0;
      cap_q       <= '0;
      cap_qid_q   <= '0;
      cap_dcp_q   <= 1'b0;
      cap_port_q  <= '0;
      cap_memid_q <= '0;
      cap_eaddr_q <= '0;
      data_q      <= '0;
    end else begin
      status_q <= (status_q & ~(we_stat ? reg_wdata : 32'd0)) | evm;
      if (we_en)  en_q  <= reg_wdata;
      if (we_dis) dis_q <= reg_wdata;
      if (we_inh) inh_q <= reg_wdata[0];
      if (take) begin
        cap_q       <= hot;
        cap_qid_q   <= q_cls ? evt_qid   : '0;
        cap_dcp_q   <= p_cls ? evt_dcp   : 1'b0;
        cap_port_q  <= p_cls ? evt_port  : '0;
        cap_memid_q <= e_cls ? evt_memid : '0;
        cap_eaddr_q <= e_cls ? evt_eaddr : '0;
        data_q      <= e_cls ? evt_edata : '0;
      end else if (we_cap) begin
        cap_q <= cap_q & ~reg_wdata;
      end
    end
  end

  logic [IDX_W-1:0] didx;
  assign didx = IDX_W'(reg_addr - A_DATA);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_STAT: reg_rdata = status_q;
      A_EN:   reg_rdata = en_q;
      A_DIS:  reg_rdata = dis_q;
      A_INH:  reg_rdata = {31'd0, inh_q};
      A_CAP:  reg_rdata = cap_q;
      A_QID:  reg_rdata = 32'(cap_qid_q);
      A_PORT: reg_rdata = {cap_dcp_q, 31'(cap_port_q)};
      A_ECC:  reg_rdata = (32'(cap_memid_q) << 24) | 32'(cap_eaddr_q);
      default:
        if (reg_addr >= A_DATA && 32'(reg_addr) < 32'(8 + DATA_WORDS))
          reg_rdata = data_q[32*didx +: 32];
    endcase
  end
endmodule

module err_capture_chk #(
  parameter int QID_W   = 24,
  parameter int PORT_W  = 10,
  parameter int EADDR_W = 16,
  parameter int ADDR_W  = 5
)(
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [31:0]        reg_wdata,
  input logic [31:0]        evt,
  input logic               irq,
  input logic [31:0]        status_q,
  input logic [31:0]        cap_q,
  input logic [QID_W-1:0]   cap_qid_q,
  input logic [PORT_W-1:0]  cap_port_q,
  input logic [EADDR_W-1:0] cap_eaddr_q
);
  // R1
  evt_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt & 32'h3F83_0F1F) != 0 |=> (status_q & $past(evt & 32'h3F83_0F1F)) == $past(evt & 32'h3F83_0F1F));
  // R2
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(0) && evt == 0) |=> (status_q & $past(reg_wdata)) == 0);
  // R3
  inhibit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(3) && reg_wdata[0]) |=> !irq);
  // R4
  cap_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(cap_q));
  // R8
  frozen_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_q != 0 && !(reg_wr && reg_addr == ADDR_W'(4))) |=>
      ($stable(cap_q) && $stable(cap_qid_q) && $stable(cap_port_q) && $stable(cap_eaddr_q)));
endmodule

bind err_capture_unit err_capture_chk #(
  .QID_W(QID_W), .PORT_W(PORT_W), .EADDR_W(EADDR_W), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .evt(evt), .irq(irq), .status_q(status_q), .cap_q(cap_q), .cap_qid_q(cap_qid_q),
  .cap_port_q(cap_port_q), .cap_eaddr_q(cap_eaddr_q)
);

// File: tb/err_capture_unit_tb_top.sv
`timescale 1ns/1ps
module err_capture_unit_tb_top;
  localparam int NW = 16;
  localparam int AW = $clog2(8 + NW);
  localparam logic [31:0] VALID_M = 32'h3F83_0F1F;
  localparam logic [31:0] PORT_M  = 32'h0003_0F0D;
  localparam logic [31:0] QID_M   = 32'h0002_051F;
  localparam logic [31:0] ECC_M   = 32'h0300_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata, evt = '0;
  logic evt_dcp = 1'b0;
  logic [9:0] evt_port = '0;
  logic [23:0] evt_qid = '0;
  logic [4:0] evt_memid = '0;
  logic [15:0] evt_eaddr = '0;
  logic [NW*32-1:0] evt_edata = '0;
  logic irq;

  always #10 clk = ~clk;

  err_capture_unit dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .evt(evt), .evt_dcp(evt_dcp), .evt_port(evt_port), .evt_qid(evt_qid),
    .evt_memid(evt_memid), .evt_eaddr(evt_eaddr), .evt_edata(evt_edata), .irq(irq)
  );

  int n_run = 0, n_fail = 0;
  logic [31:0] m_stat, m_en, m_dis, m_cap, m_qid, m_port, m_ecc;
  logic m_inh;
  logic [31:0] m_data [NW];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    reg_addr = AW'(a);
    #1 d = reg_rdata;
  endtask

  task automatic check_all(input string ctx);
    logic [31:0] d;
    rd(0, d); chk({ctx, " R1 R2 status"}, d, m_stat);
    rd(1, d); chk({ctx, " R3 enable"}, d, m_en);
    rd(2, d); chk({ctx, " R10 disable"}, d, m_dis);
    rd(3, d); chk({ctx, " R3 inhibit"}, d, {31'd0, m_inh});
    rd(4, d); chk({ctx, " R4 R9 capstat"}, d, m_cap);
    rd(5, d); chk({ctx, " R6 qid"}, d, m_qid);
    rd(6, d); chk({ctx, " R5 portal"}, d, m_port);
    rd(7, d); chk({ctx, " R7 eccaddr"}, d, m_ecc);
    for (int i = 0; i < NW; i++) begin
      rd(8 + i, d); chk({ctx, " R7 data"}, d, m_data[i]);
    end
    chk({ctx, " R3 irq"}, {31'd0, irq}, {31'd0, (|(m_stat & m_en)) && !m_inh});
  endtask

  function automatic int highest(input logic [31:0] v);
    int h = -1;
    for (int i = 31; i >= 0; i--) if (v[i] && h < 0) h = i;
    return h;
  endfunction

  task automatic new_ctx();
    evt_dcp   = 1'($urandom);
    evt_port  = 10'($urandom);
    evt_qid   = 24'($urandom);
    evt_memid = 5'($urandom);
    evt_eaddr = 16'($urandom);
    for (int i = 0; i < NW; i++) evt_edata[32*i +: 32] = $urandom;
  endtask

  task automatic step(input logic [31:0] e, input logic w, input int a, input logic [31:0] wd);
    logic [31:0] evm, elig, clr, capclr;
    logic armed;
    int h;
    @(negedge clk);
    evt = e; reg_wr = w; reg_addr = AW'(a); reg_wdata = wd;
    @(posedge clk);
    #1;
    reg_wr = 1'b0; evt = '0;
    evm = e & VALID_M;
    elig = evm & ~m_dis;
    armed = (m_cap == 0);
    clr = (w && a == 0) ? wd : 32'd0;
    capclr = (w && a == 4) ? wd : 32'd0;
    m_stat = (m_stat & ~clr) | evm;
    if (armed && elig != 0) begin
      h = highest(elig);
      m_cap  = 32'd1 << h;
      m_qid  = QID_M[h]  ? {8'd0, evt_qid} : 32'd0;
      m_port = PORT_M[h] ? {evt_dcp, 21'd0, evt_port} : 32'd0;
      m_ecc  = ECC_M[h]  ? {3'd0, evt_memid, 8'd0, evt_eaddr} : 32'd0;
      for (int i = 0; i < NW; i++) m_data[i] = ECC_M[h] ? evt_edata[32*i +: 32] : 32'd0;
    end else begin
      m_cap = m_cap & ~capclr;
    end
    if (w && a == 1) m_en = wd;
    if (w && a == 2) m_dis = wd;
    if (w && a == 3) m_inh = wd[0];
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_stat = 0; m_en = 0; m_dis = 0; m_cap = 0; m_qid = 0; m_port = 0; m_ecc = 0; m_inh = 0;
    for (int i = 0; i < NW; i++) m_data[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1 check_all("R11 reset");

    step(32'h0, 1, 1, 32'hFFFF_FFFF);
    step(32'h8000_0020, 0, 0, 0);            // undefined positions only
    check_all("R1 undefined ignored");

    new_ctx();
    step(32'h0102_0000, 0, 0, 0);            // bits 24 and 17 together
    check_all("R4 R7 highest wins");

    new_ctx();
    step(32'h0000_0001, 0, 0, 0);
    check_all("R8 frozen");

    step(32'h0, 1, 3, 32'h1);
    check_all("R3 inhibit set");
    step(32'h0, 1, 3, 32'h0);

    step(32'h0, 1, 4, m_cap);
    check_all("R9 rearm");
    new_ctx();
    step(32'h0000_0400, 0, 0, 0);
    check_all("R5 R6 portal qid");

    step(32'h0, 1, 4, m_cap);
    step(32'h0, 1, 2, 32'h0000_0100);
    new_ctx();
    step(32'h0000_0100, 0, 0, 0);
    check_all("R10 masked");

    step(32'h0400_0000, 1, 0, 32'hFFFF_FFFF);
    check_all("R2 set beats clear");

    step(32'h0, 1, 1, 32'hFBFF_FFFF);
    check_all("R3 enable dropped");

    for (int n = 0; n < 2500; n++) begin
      logic [31:0] e, wd;
      logic w;
      int a;
      new_ctx();
      e  = ($urandom % 3 == 0) ? ($urandom & (($urandom % 4 == 0) ? 32'hFFFF_FFFF : VALID_M)) : 32'd0;
      if ($urandom % 5 == 0) e = 32'd1 << ($urandom % 32);
      w  = ($urandom % 3 == 0);
      a  = $urandom % 9;
      wd = $urandom;
      if (a == 4 && ($urandom % 2 == 0)) wd = m_cap;
      if (a == 2 && ($urandom % 2 == 0)) wd = 32'd0;
      step(e, w, a, wd);
      check_all("R1 R4 R8 R9 random");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule